// File: doc/BRIEF.md
# Fixed-Point Two-Layer Neural Inference Core

This block evaluates a small fully connected classifier in signed 16-bit fixed point with 15 fraction bits. The first layer maps `N_IN` input samples (784 by default) to `N_HID` hidden neurons (10). The second layer maps those hidden values to `N_OUT` output neurons (10). The block then reports the index of the strongest output as a 4-bit class, together with a one-cycle done pulse. A single multiply-accumulate unit serves every neuron of both layers, one weight per cycle. Each 16x16 product is kept as a 32-bit value with 30 fraction bits and summed in a wide accumulator.

Before a run, software loads weights and biases into an internal parameter memory through a simple write port. The write port is honoured only while the core is not busy. The image sits in an external buffer. The core drives a sample index and expects the matching sample on `in_data` in the same cycle. A `start` pulse begins a run, `busy` stays high for the whole forward pass, and `done` then pulses for one cycle with `class_idx` valid.

Top module: `nn_infer_core`

## Requirements
- R1: When `start` is sampled high while the core is not busy, `busy` is high for exactly LAT = N_HID*(N_IN+1) + N_OUT*(N_HID+1) cycles (7960 by default). In the next cycle `done` is high for one cycle with `busy` low, and then both are low.
- R2: A write with `wr_en` high while `busy` is low stores `wr_data` at `wr_addr`. The memory is laid out as follows: the layer-1 weight for hidden neuron j and input i sits at j*N_IN+i. The layer-1 bias j sits at N_IN*N_HID+j. The layer-2 weight for output k and hidden h sits at N_IN*N_HID+N_HID+k*N_HID+h. The layer-2 bias k follows those weights, at N_IN*N_HID+N_HID+N_HID*N_OUT+k.
- R3: A write presented while `busy` is high leaves the parameter memory unchanged.
- R4: Each neuron sums the full-precision 32-bit products of its weights and operands in an accumulator wide enough that no sum of N_IN products overflows. It then adds its bias shifted left by 15 bits, with the sign kept.
- R5: A hidden neuron's sum passes through ReLU, is arithmetically shifted right by 15 bits, and saturates to 0x7FFF. The result is the layer-2 operand.
- R6: An output neuron's sum passes through ReLU before the comparison, so any negative output counts as zero.
- R7: `class_idx` during `done` is the index of the largest output. On a tie the lower index wins, so when all outputs are zero the class is 0.
- R8: A `start` pulse that arrives while `busy` is high has no effect on the run in progress or on its latency.
- R9: After reset, `busy`, `done` and `class_idx` are all zero.
- R10: In layer-1 cycles `in_addr` names the sample being multiplied. The core uses the `in_data` value present in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a forward pass when the core is not busy |
| busy | output | 1 | High while a forward pass runs |
| done | output | 1 | One-cycle pulse at the end of a pass |
| class_idx | output | CLS_W (4) | Predicted class, valid during `done` |
| in_addr | output | IN_AW (10) | Index of the requested input sample |
| in_data | input | 16 | Signed Q1.15 sample for `in_addr`, same cycle |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | MEM_AW (13) | Parameter memory address |
| wr_data | input | 16 | Signed Q1.15 weight or bias |

## Verification
The assertions assume three things about the inputs. The external buffer returns a defined sample in the same cycle `in_addr` changes. Write addresses stay below the memory depth. The accumulator width meets the elaboration check, so no legal operand pattern can overflow it. The stimulus keeps within this: the bench drives `in_data` combinationally from a model array indexed by `in_addr`, it writes only addresses from the documented map, and it uses operand ranges that include full-scale values for the saturation case. It also pokes an illegal write and a second start into a running pass, to show that both are dropped.

// File: rtl/nn_pkg.sv
package nn_pkg;

   localparam int Q_W    = 16;
   localparam int Q_FRAC = 15;
   localparam int PROD_W = 2 * Q_W;

   typedef logic signed [Q_W-1:0] q15_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_MAC,
      ST_L1_FIN,
      ST_L2_MAC,
      ST_L2_FIN,
      ST_DONE
   } nn_state_e;

endpackage

// File: rtl/nn_param_mem.sv
module nn_param_mem #(
   parameter int DEPTH = 7960,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lock,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  nn_pkg::q15_t   wr_data,
   input  logic [AW-1:0]  rd_addr,
   output nn_pkg::q15_t   rd_data
);

   generate
      if (DEPTH < 2) begin : g_depth_chk
         $error("nn_param_mem: DEPTH must be at least 2");
      end
   endgenerate

   nn_pkg::q15_t mem [DEPTH];
   logic         wr_ok;

   assign wr_ok   = wr_en && !lock && (32'(wr_addr) < DEPTH);
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= wr_data;
   end

   // R3: a locked write must leave the addressed word untouched
   assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock && (32'(wr_addr) < DEPTH)) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));

endmodule

// File: rtl/nn_mac.sv
module nn_mac #(
   parameter int ACC_W = 42
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    clr,
   input  nn_pkg::q15_t            op_a,
   input  nn_pkg::q15_t            op_b,
   output logic signed [ACC_W-1:0] acc
);
   import nn_pkg::*;

   generate
      if (ACC_W < PROD_W + 2) begin : g_width_chk
         $error("nn_mac: ACC_W too narrow for one product");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W:0]    wide_sum;

   assign prod     = op_a * op_b;
   assign wide_sum = {acc[ACC_W-1], acc} + {{(ACC_W+1-PROD_W){prod[PROD_W-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= wide_sum[ACC_W-1:0];
   end

   // R4: the sum must stay representable in ACC_W bits
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

endmodule

// File: rtl/nn_argmax.sv
module nn_argmax #(
   parameter int VAL_W = 42,
   parameter int N     = 10,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    upd,
   input  logic signed [VAL_W-1:0] val,
   input  logic [IDX_W-1:0]        idx,
   output logic [IDX_W-1:0]        best_idx
);

   generate
      if (N < 2) begin : g_n_chk
         $error("nn_argmax: N must be at least 2");
      end
   endgenerate

   logic signed [VAL_W-1:0] best_val;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         best_val <= '0;
         best_idx <= '0;
      end else if (upd && (val > best_val)) begin
         best_val <= val;
         best_idx <= idx;
      end
   end

   // R6: candidates reaching the comparator are already rectified
   assert_relu_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> !val[VAL_W-1]);

   // R7: an equal candidate never displaces the earlier (lower) index
   assert_tie_keeps_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && (val == best_val)) |=> (best_idx == $past(best_idx)));

   // R7: reported index stays inside the output range
   assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(best_idx) < N);

endmodule

// File: rtl/nn_infer_core.sv
module nn_infer_core #(
   parameter int N_IN  = 784,
   parameter int N_HID = 10,
   parameter int N_OUT = 10,
   parameter int ACC_W = 42,
   localparam int MEM_DEPTH = N_IN*N_HID + N_HID + N_HID*N_OUT + N_OUT,
   localparam int MEM_AW    = $clog2(MEM_DEPTH),
   localparam int IN_AW     = $clog2(N_IN),
   localparam int CLS_W     = $clog2(N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [CLS_W-1:0]  class_idx,
   output logic [IN_AW-1:0]  in_addr,
   input  logic [15:0]       in_data,
   input  logic              wr_en,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [15:0]       wr_data
);
   import nn_pkg::*;

   localparam int L1_BIAS = N_IN*N_HID;
   localparam int L2_W    = L1_BIAS + N_HID;
   localparam int L2_BIAS = L2_W + N_HID*N_OUT;
   localparam int N_MAX   = (N_HID > N_OUT) ? N_HID : N_OUT;
   localparam int NW      = $clog2(N_MAX);
   localparam int HID_AW  = $clog2(N_HID);

   generate
      if (N_IN < 2 || N_HID < 2 || N_OUT < 2) begin : g_shape_chk
         $error("nn_infer_core: every layer needs at least two neurons");
      end
      if (N_HID > N_IN) begin : g_fan_chk
         $error("nn_infer_core: N_HID must not exceed N_IN");
      end
      if (ACC_W < PROD_W + $clog2(N_IN + 1)) begin : g_acc_chk
         $error("nn_infer_core: ACC_W cannot hold N_IN products plus bias");
      end
   endgenerate

   nn_state_e               state;
   logic [IN_AW-1:0]        icnt;
   logic [NW-1:0]           ncnt;
   logic [MEM_AW-1:0]       waddr;
   logic [MEM_AW-1:0]       rd_addr;
   q15_t                    mem_q;
   q15_t                    hid [N_HID];
   q15_t                    mac_b;
   logic                    mac_en;
   logic                    mac_clr;
   logic                    launch;
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] pre_act;
   logic signed [ACC_W-1:0] act;
   q15_t                    hid_q;

   assign busy    = (state != ST_IDLE) && (state != ST_DONE);
   assign done    = (state == ST_DONE);
   assign launch  = start && !busy;
   assign in_addr = icnt;

   // operand select: image samples in layer 1, stored activations in layer 2
   always_comb begin
      if (state == ST_L2_MAC) mac_b = hid[icnt[HID_AW-1:0]];
      else                    mac_b = q15_t'(in_data);
   end

   always_comb begin
      unique case (state)
         ST_L1_FIN: rd_addr = MEM_AW'(L1_BIAS) + MEM_AW'(ncnt);
         ST_L2_FIN: rd_addr = MEM_AW'(L2_BIAS) + MEM_AW'(ncnt);
         default:   rd_addr = waddr;
      endcase
   end

   assign mac_en  = (state == ST_L1_MAC) || (state == ST_L2_MAC);
   assign mac_clr = (state == ST_L1_FIN) || (state == ST_L2_FIN);

   // bias aligned to the product scale, then rectified
   assign pre_act = acc + {{(ACC_W-Q_W-Q_FRAC){mem_q[Q_W-1]}}, mem_q, {Q_FRAC{1'b0}}};
   assign act     = pre_act[ACC_W-1] ? '0 : pre_act;
   assign hid_q   = (|act[ACC_W-1:2*Q_FRAC]) ? 16'sh7FFF : {1'b0, act[2*Q_FRAC-1:Q_FRAC]};

   nn_param_mem #(.DEPTH(MEM_DEPTH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (busy),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (q15_t'(wr_data)),
      .rd_addr (rd_addr),
      .rd_data (mem_q)
   );

   nn_mac #(.ACC_W(ACC_W)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mac_en),
      .clr   (mac_clr),
      .op_a  (mem_q),
      .op_b  (mac_b),
      .acc   (acc)
   );

   nn_argmax #(.VAL_W(ACC_W), .N(N_OUT)) u_argmax (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .upd      (state == ST_L2_FIN),
      .val      (act),
      .idx      (ncnt[CLS_W-1:0]),
      .best_idx (class_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         icnt  <= '0;
         ncnt  <= '0;
         waddr <= '0;
         for (int h = 0; h < N_HID; h++) hid[h] <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (launch) begin
                  state <= ST_L1_MAC;
                  icnt  <= '0;
                  ncnt  <= '0;
                  waddr <= '0;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_L1_MAC: begin
               waddr <= waddr + 1'b1;
               if (icnt == IN_AW'(N_IN-1)) begin
                  icnt  <= '0;
                  state <= ST_L1_FIN;
               end else begin
                  icnt <= icnt + 1'b1;
               end
            end
            ST_L1_FIN: begin
               hid[ncnt[HID_AW-1:0]] <= hid_q;
               if (ncnt == NW'(N_HID-1)) begin
                  ncnt  <= '0;
                  waddr <= MEM_AW'(L2_W);
                  state <= ST_L2_MAC;
               end else begin
                  ncnt  <= ncnt + 1'b1;
                  state <= ST_L1_MAC;
               end
            end
            ST_L2_MAC: begin
               waddr <= waddr + 1'b1;
               if (icnt == IN_AW'(N_HID-1)) begin
                  icnt  <= '0;
                  state <= ST_L2_FIN;
               end else begin
                  icnt <= icnt + 1'b1;
               end
            end
            ST_L2_FIN: begin
               if (ncnt == NW'(N_OUT-1)) begin
                  state <= ST_DONE;
               end else begin
                  ncnt  <= ncnt + 1'b1;
                  state <= ST_L2_MAC;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: completion is a single-cycle pulse outside the busy window
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: a start seen mid-run neither aborts nor restarts the pass
   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R5: the stored hidden operand is never negative
   assert_hidden_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_L2_MAC) |-> !mac_b[Q_W-1]);

endmodule

// File: tb/sim_nn_infer_core.sv
`timescale 1ns/1ps
module sim_nn_infer_core;

   localparam int N_IN  = 24;
   localparam int N_HID = 10;
   localparam int N_OUT = 10;
   localparam int MEM_DEPTH = N_IN*N_HID + N_HID + N_HID*N_OUT + N_OUT;
   localparam int MEM_AW = $clog2(MEM_DEPTH);
   localparam int IN_AW  = $clog2(N_IN);
   localparam int CLS_W  = $clog2(N_OUT);
   localparam int L1B = N_IN*N_HID;
   localparam int L2W = L1B + N_HID;
   localparam int L2B = L2W + N_HID*N_OUT;
   localparam int LAT = N_HID*(N_IN+1) + N_OUT*(N_HID+1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              busy, done;
   logic [CLS_W-1:0]  class_idx;
   logic [IN_AW-1:0]  in_addr;
   logic [15:0]       in_data;
   logic              wr_en = 1'b0;
   logic [MEM_AW-1:0] wr_addr = '0;
   logic [15:0]       wr_data = '0;

   logic signed [15:0] wm  [MEM_DEPTH];
   logic signed [15:0] img [N_IN];

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   // R10: the buffer answers combinationally for the index the core drives
   assign in_data = (32'(in_addr) < N_IN) ? img[in_addr] : 16'h0;

   nn_infer_core #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .class_idx(class_idx), .in_addr(in_addr), .in_data(in_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int predict();
      longint s, bv;
      longint h [N_HID];
      int best;
      for (int j = 0; j < N_HID; j++) begin
         s = 0;
         for (int i = 0; i < N_IN; i++) s += longint'(wm[j*N_IN+i]) * longint'(img[i]);
         s += longint'(wm[L1B+j]) <<< 15;
         if (s < 0) s = 0;
         s = s >>> 15;
         if (s > 32767) s = 32767;
         h[j] = s;
      end
      bv = 0;
      best = 0;
      for (int k = 0; k < N_OUT; k++) begin
         s = 0;
         for (int j = 0; j < N_HID; j++) s += longint'(wm[L2W+k*N_HID+j]) * h[j];
         s += longint'(wm[L2B+k]) <<< 15;
         if (s < 0) s = 0;
         if (s > bv) begin bv = s; best = k; end
      end
      return best;
   endfunction

   task automatic clear_model();
      for (int a = 0; a < MEM_DEPTH; a++) wm[a] = '0;
      for (int i = 0; i < N_IN; i++) img[i] = '0;
   endtask

   // R2: parameters loaded through the write port while idle
   task automatic load_params();
      for (int a = 0; a < MEM_DEPTH; a++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = MEM_AW'(a); wr_data = wm[a];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_case(input string tag, input bit poke_wr, input bit poke_st);
      int exp_cls, cnt;
      exp_cls = predict();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cnt = 0;
      while (busy && cnt < LAT + 20) begin
         cnt++;
         // R3: an illegal write that would flip the result if it landed
         if (poke_wr && cnt == 3) begin
            wr_en = 1'b1; wr_addr = MEM_AW'(L2B + ((exp_cls + 1) % N_OUT)); wr_data = 16'h7FFF;
         end else wr_en = 1'b0;
         // R8: a second start in the middle of the pass
         start = (poke_st && cnt == 7);
         @(negedge clk);
      end
      wr_en = 1'b0; start = 1'b0;
      chk(cnt == LAT, "R1", {tag, " busy length"}, cnt, LAT);
      chk(done == 1'b1, "R1", {tag, " done after busy"}, done, 1);
      chk(int'(class_idx) == exp_cls, "R7", {tag, " class"}, class_idx, exp_cls);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R1", {tag, " done pulse width"}, {done, busy}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
      chk(done == 1'b0, "R9", "done in reset", done, 0);
      chk(class_idx == '0, "R9", "class in reset", class_idx, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7/R6: all-zero network gives class 0
      clear_model();
      load_params();
      run_case("zero net R6", 1'b0, 1'b0);

      // R7: tie between 3 and 7 resolves low; R3 illegal write dropped
      clear_model();
      for (int k = 0; k < N_OUT; k++) wm[L2B+k] = 16'sh1000;
      wm[L2B+3] = 16'sh2000;
      wm[L2B+7] = 16'sh2000;
      load_params();
      run_case("tie R3", 1'b1, 1'b0);

      // R6: negative outputs clipped; only neuron 5 is positive
      clear_model();
      for (int k = 0; k < N_OUT; k++) wm[L2B+k] = -16'sh7000;
      wm[L2B+5] = 16'sh0010;
      load_params();
      run_case("negative outputs R6", 1'b0, 1'b0);

      // R7: boundary at the highest index
      clear_model();
      wm[L2B+N_OUT-1] = 16'sh0100;
      load_params();
      run_case("last index R7", 1'b0, 1'b1);

      // R5: full-scale layer 1 saturates the hidden values
      clear_model();
      for (int i = 0; i < N_IN; i++) img[i] = 16'sh7FFF;
      for (int a = 0; a < L1B; a++) wm[a] = 16'sh7FFF;
      for (int i = 0; i < N_IN; i++) wm[N_IN+i] = -16'sh7FFF;
      wm[L2W + 4*N_HID + 0] = 16'sh4000;
      wm[L2W + 6*N_HID + 1] = 16'sh7FFF;
      wm[L2W + 8*N_HID + 2] = 16'sh3000;
      load_params();
      run_case("saturation R5", 1'b0, 1'b0);

      // R4/R10: random networks and images
      for (int t = 0; t < 12; t++) begin
         for (int i = 0; i < N_IN; i++)
            img[i] = (t % 2 == 0) ? 16'($urandom_range(0, 32767)) : 16'($urandom);
         for (int a = 0; a < L2W; a++)
            wm[a] = 16'(int'($urandom_range(0, 16'h1FFF)) - 16'h1000);
         for (int a = L2W; a < MEM_DEPTH; a++) wm[a] = 16'($urandom);
         load_params();
         run_case($sformatf("random %0d R4 R10", t), (t % 3 == 0), (t % 4 == 1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule